// File: doc/BRIEF.md
# Two-Phase Conditional Forwarding Handshake Controller

This controller sits between a requester and a costly computation unit. Every handshake line uses transition signalling: any toggle, rising or falling, is one event, and the level of the line carries no meaning. When the requester toggles its request line, the controller samples a level-type select input at that moment. A high select forwards the event: the controller toggles a start line to the computation unit. It then waits for that unit's done toggle before it toggles the acknowledge back to the requester. A low select takes a bypass: the acknowledge toggles directly, and the start line is left alone.

The block is a clocked model. The request and done inputs are taken as already synchronous. An event on either input is found by comparing the input with a copy registered one cycle earlier. The bypass acknowledge is produced in the clock edge that detects the request, so no extra state change comes before the output. A sticky flag records handshake misuse by the environment.

Top module: `twophase_select_ctrl`

## Requirements
- R1: A synchronous active-high reset drives ack_tgl, start_tgl, busy and proto_err to 0, returns the controller to idle and clears the registered copies of req_tgl and done_tgl.
- R2: In idle, a req_tgl event with sel high toggles start_tgl and raises busy at the first clock edge after the event, and ack_tgl holds its value.
- R3: While busy, a done_tgl event toggles ack_tgl and clears busy at the first clock edge after the event, and start_tgl holds its value.
- R4: In idle, a req_tgl event with sel low toggles ack_tgl at the first clock edge after the event, leaves start_tgl unchanged and keeps busy low.
- R5: sel matters only in the cycle that a req_tgl event is detected. A change of sel at any other time leaves all outputs unchanged.
- R6: A falling transition on req_tgl or done_tgl is an event with the same effect as a rising one.
- R7: A req_tgl event while busy sets proto_err. It produces no acknowledge, and busy stays high.
- R8: A done_tgl event while idle sets proto_err and leaves ack_tgl, start_tgl and busy unchanged.
- R9: proto_err stays at 1 once it is set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_tgl | input | 1 | Upstream request; each toggle is one request |
| sel | input | 1 | Level select, sampled at a request event (1 = forward, 0 = bypass) |
| done_tgl | input | 1 | Completion from the computation unit; each toggle is one completion |
| ack_tgl | output | 1 | Upstream acknowledge; each toggle is one acknowledge |
| start_tgl | output | 1 | Downstream start; each toggle launches one operation |
| busy | output | 1 | High while waiting for a completion |
| proto_err | output | 1 | Sticky handshake-misuse flag |

## Verification
The block has no parameters, so the bench builds the single default configuration. That build covers rising and falling events on both inputs, select moving while idle and while busy, and each misuse case, which is followed by a reset. A behavioural reference, advanced once per clock, is compared with all four outputs on every cycle.

// File: rtl/twophase_select_ctrl.sv
module twophase_select_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic req_tgl,
  input  logic sel,
  input  logic done_tgl,
  output logic ack_tgl,
  output logic start_tgl,
  output logic busy,
  output logic proto_err
);

  typedef enum logic {IDLE = 1'b0, WAIT_DONE = 1'b1} ctrl_state_t;

  ctrl_state_t state;
  logic req_seen, done_seen;
  logic req_ev, done_ev;

  assign req_ev  = req_tgl ^ req_seen;
  assign done_ev = done_tgl ^ done_seen;
  assign busy    = (state == WAIT_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_seen  <= 1'b0;
      done_seen <= 1'b0;
    end else begin
      req_seen  <= req_tgl;
      done_seen <= done_tgl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= IDLE;
      ack_tgl   <= 1'b0;
      start_tgl <= 1'b0;
    end else if (state == IDLE) begin
      if (req_ev) begin
        if (sel) begin
          start_tgl <= ~start_tgl;
          state     <= WAIT_DONE;
        end else begin
          ack_tgl   <= ~ack_tgl;
        end
      end
    end else if (done_ev) begin
      ack_tgl <= ~ack_tgl;
      state   <= IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      proto_err <= 1'b0;
    else if ((busy && req_ev) || (!busy && done_ev))
      proto_err <= 1'b1;
  end

endmodule

module twophase_select_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic req_tgl,
  input logic sel,
  input logic done_tgl,
  input logic ack_tgl,
  input logic start_tgl,
  input logic busy,
  input logic proto_err,
  input logic req_seen,
  input logic done_seen
);

  logic rq_ev, dn_ev;
  assign rq_ev = req_tgl != req_seen;
  assign dn_ev = done_tgl != done_seen;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!ack_tgl && !start_tgl && !busy && !proto_err));

  p_forward_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && rq_ev && sel) |=> (busy && start_tgl != $past(start_tgl) && $stable(ack_tgl)));

  p_complete_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && dn_ev) |=> (!busy && ack_tgl != $past(ack_tgl) && $stable(start_tgl)));

  p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && rq_ev && !sel) |=> (!busy && ack_tgl != $past(ack_tgl) && $stable(start_tgl)));

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!rq_ev && !dn_ev) |=> ($stable(ack_tgl) && $stable(start_tgl) && $stable(busy)));

  p_req_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && rq_ev && !dn_ev) |=> (proto_err && busy && $stable(ack_tgl)));

  p_stray_done_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && dn_ev) |=> proto_err);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);

endmodule

bind twophase_select_ctrl twophase_select_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_tgl(req_tgl), .sel(sel), .done_tgl(done_tgl),
  .ack_tgl(ack_tgl), .start_tgl(start_tgl), .busy(busy), .proto_err(proto_err),
  .req_seen(req_seen), .done_seen(done_seen)
);

// File: tb/tb_twophase_select_ctrl.sv
module tb_twophase_select_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_tgl = 1'b0, sel = 1'b0, done_tgl = 1'b0;
  logic ack_tgl, start_tgl, busy, proto_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;
  string tag = "R1";

  int m_ack = 0, m_start = 0, m_busy = 0, m_err = 0, m_rq = 0, m_dq = 0;

  twophase_select_ctrl dut (
    .clk(clk), .rst(rst), .req_tgl(req_tgl), .sel(sel), .done_tgl(done_tgl),
    .ack_tgl(ack_tgl), .start_tgl(start_tgl), .busy(busy), .proto_err(proto_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference, advanced once per clock
  always @(posedge clk) begin
    int rq_hit, dn_hit;
    if (rst) begin
      m_ack = 0; m_start = 0; m_busy = 0; m_err = 0; m_rq = 0; m_dq = 0;
    end else begin
      rq_hit = (int'(req_tgl) != m_rq);
      dn_hit = (int'(done_tgl) != m_dq);
      if (m_busy == 1) begin
        if (rq_hit) m_err = 1;
        if (dn_hit) begin m_ack = 1 - m_ack; m_busy = 0; end
      end else begin
        if (dn_hit) m_err = 1;
        if (rq_hit) begin
          if (sel) begin m_start = 1 - m_start; m_busy = 1; end
          else m_ack = 1 - m_ack;
        end
      end
      m_rq = int'(req_tgl);
      m_dq = int'(done_tgl);
    end
  end

  task automatic check(input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      check("model ack_tgl", int'(ack_tgl), m_ack);
      check("model start_tgl", int'(start_tgl), m_start);
      check("model busy", int'(busy), m_busy);
      check("model proto_err", int'(proto_err), m_err);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req_tgl = 1'b0; done_tgl = 1'b0;
    tick(2); rst = 1'b0;
  endtask

  initial begin
    logic a0, s0;
    tick(3); rst = 1'b0;
    tag = "R1";
    check("ack after reset", int'(ack_tgl), 0);
    check("start after reset", int'(start_tgl), 0);
    check("busy after reset", int'(busy), 0);
    check("err after reset", int'(proto_err), 0);

    // R4 bypass on a rising request
    tag = "R4"; sel = 1'b0; req_tgl = 1'b1; tick(1);
    check("bypass ack", int'(ack_tgl), 1);
    check("bypass start held", int'(start_tgl), 0);
    check("bypass not busy", int'(busy), 0);

    // R2 + R6 forward on a falling request
    tag = "R6"; sel = 1'b1; req_tgl = 1'b0; tick(1);
    check("forward start on falling req (R2)", int'(start_tgl), 1);
    check("forward busy (R2)", int'(busy), 1);
    check("forward ack held (R2)", int'(ack_tgl), 1);

    // R5 select moves while busy
    tag = "R5"; sel = 1'b0; tick(2); sel = 1'b1; tick(1);
    check("sel wiggle ack held", int'(ack_tgl), 1);
    check("sel wiggle busy held", int'(busy), 1);

    // R3 completion on rising done
    tag = "R3"; done_tgl = 1'b1; tick(1);
    check("complete ack", int'(ack_tgl), 0);
    check("complete not busy", int'(busy), 0);
    check("complete start held", int'(start_tgl), 1);

    // R5 select moves while idle
    tag = "R5"; sel = 1'b0; tick(1); sel = 1'b1; tick(1); sel = 1'b0; tick(1);
    check("idle sel ack", int'(ack_tgl), 0);
    check("idle sel start", int'(start_tgl), 1);

    // R6 forward then falling completion
    tag = "R6"; sel = 1'b1; req_tgl = 1'b1; tick(1); sel = 1'b0;
    check("second forward start", int'(start_tgl), 0);
    tick(3);
    done_tgl = 1'b0; tick(1);
    check("falling done ack", int'(ack_tgl), 1);
    check("falling done idle", int'(busy), 0);
    check("no error so far", int'(proto_err), 0);

    // R8 stray completion while idle
    tag = "R8"; a0 = ack_tgl; s0 = start_tgl;
    done_tgl = 1'b1; tick(1);
    check("stray done err", int'(proto_err), 1);
    check("stray done ack held", int'(ack_tgl), int'(a0));
    check("stray done start held", int'(start_tgl), int'(s0));
    check("stray done idle", int'(busy), 0);

    // R9 sticky flag, cleared by reset
    tag = "R9"; sel = 1'b0; req_tgl = ~req_tgl; tick(4);
    check("err sticky", int'(proto_err), 1);
    do_reset(); tick(1);
    check("err cleared by reset", int'(proto_err), 0);

    // R7 second request while busy
    tag = "R7"; sel = 1'b1; req_tgl = 1'b1; tick(1);
    check("busy before misuse", int'(busy), 1);
    req_tgl = 1'b0; tick(1);
    check("misuse err", int'(proto_err), 1);
    check("misuse busy held", int'(busy), 1);
    check("misuse no ack", int'(ack_tgl), 0);
    done_tgl = 1'b1; tick(1);
    check("completion after misuse", int'(ack_tgl), 1);

    tick(2);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule